// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a byte-wide serial slave reach the 16-bit address space of an on-chip control processor through a small window. The window has three subaddresses: a read pointer, a write pointer and a data register. Every 16-bit quantity crosses the byte side as two bytes, and the serial slave says with each access whether it carries the upper or the lower byte.

To fetch a word, the host loads the read pointer, upper byte first. Loading the lower byte starts a processor read. The processor's acknowledge places the returned word in the data register, and the host then reads it out, upper byte first. To store a word, the host loads the write pointer and then writes the data register, upper byte first. The lower data byte starts a processor write to the stored pointer.

While a transfer is pending, the bridge asks the serial slave to stretch the clock on any data-register access. It ignores pointer loads and data writes, so the pending transfer completes with the values it started with.

Top module: `ibr_bridge`

## Requirements
- R1: After reset all three registers read as zero, and `pr_req` and `host_stretch` are low.
- R2: A write to subaddress 0 (read pointer) or 1 (write pointer) with `host_lo`=0 loads bits 15:8, and with `host_lo`=1 loads bits 7:0. A read of the same subaddress with the same `host_lo` returns that byte.
- R3: When idle, a write to subaddress 0 with `host_lo`=1 raises `pr_req` at the next clock edge, with `pr_we`=0 and `pr_addr` equal to the completed read pointer.
- R4: A processor acknowledge of a read loads `pr_rdata` into the data register (subaddress 2). A read of subaddress 2 returns bits 15:8 when `host_lo`=0 and bits 7:0 when `host_lo`=1.
- R5: When idle and with a write pointer loaded since the last processor write, a write to subaddress 2 with `host_lo`=1 raises `pr_req` with `pr_we`=1, `pr_addr` equal to the write pointer and `pr_wdata` equal to the full data register. Without such a pointer load, the same write starts no request.
- R6: `pr_req` stays high until a cycle with `pr_ack` high, and falls at the edge that samples the acknowledge.
- R7: `host_stretch` is high exactly when a request is pending and the host is accessing subaddress 2.
- R8: While a request is pending, writes to either pointer are ignored, and `pr_addr` and `pr_we` hold.
- R9: While a request is pending, writes to the data register are ignored, and `pr_wdata` holds.
- R10: Subaddress 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Byte write strobe from the serial slave |
| host_rd | input | 1 | Byte read strobe from the serial slave |
| host_sel | input | 2 | Subaddress: 0 read pointer, 1 write pointer, 2 data, 3 unused |
| host_lo | input | 1 | 0 selects the upper byte, 1 the lower byte |
| host_wdata | input | BYTE_W | Byte written by the host |
| host_rdata | output | BYTE_W | Byte returned to the host (combinational) |
| host_stretch | output | 1 | Request to stretch the serial clock |
| pr_req | output | 1 | Processor request, held until acknowledged |
| pr_we | output | 1 | 1 for a processor write, 0 for a read |
| pr_addr | output | 2*BYTE_W | Processor address |
| pr_wdata | output | 2*BYTE_W | Processor write data |
| pr_ack | input | 1 | Processor acknowledge, one cycle |
| pr_rdata | input | 2*BYTE_W | Processor read data, valid with `pr_ack` |

## Verification
The hardest case to reach is a host access that lands while a request is still pending. With a quick processor, that window lasts only a cycle or two. The bench models the processor with a random acknowledge delay, so random traffic collides with pending requests at uneven offsets. A directed case holds the acknowledge back entirely while the host reloads both pointers and rewrites the data register, and then checks that the stored values and the request fields did not move.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the indirect register access bridge.
// Assumes the host subaddress field is two bits wide.
package ibr_pkg;
    typedef enum logic [1:0] {
        SEL_RPTR = 2'd0,
        SEL_WPTR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } ibr_sel_e;
endpackage

// File: rtl/ibr_word_reg.sv
`timescale 1ns/1ps
// Two-byte holding register. It takes byte writes (upper or lower half)
// or a full-word load, and the full-word load wins.
// Assumes the caller gates the enables with its own busy rules.
module ibr_word_reg #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic              byte_lo,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              word_ld,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] q
);
    // Hold the word: reset to zero, then apply a full load or a byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (word_ld) begin
            q <= word_in;
        end else if (byte_we) begin
            if (byte_lo) q[BYTE_W-1:0]      <= byte_in;
            else         q[WORD_W-1:BYTE_W] <= byte_in;
        end
    end
endmodule

// File: rtl/ibr_seq.sv
`timescale 1ns/1ps
// Request sequencer toward the processor. A start captures the direction
// and the address and raises the request, which stays up until acknowledged.
// Assumes starts arrive only while idle.
module ibr_seq #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [WORD_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] wr_addr,
    input  logic              ack,
    output logic              req,
    output logic              we,
    output logic [WORD_W-1:0] addr
);
    // Raise the request on a start and drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     req <= 1'b0;
        else if (req && ack)            req <= 1'b0;
        else if (start_rd || start_wr)  req <= 1'b1;
    end

    // Capture direction and address when a request starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we   <= 1'b0;
            addr <= '0;
        end else if (!req && (start_rd || start_wr)) begin
            we   <= start_wr;
            addr <= start_wr ? wr_addr : rd_addr;
        end
    end
endmodule

// File: rtl/ibr_bridge.sv
`timescale 1ns/1ps
// Indirect register access bridge: the top of the block.
// It decodes byte-level host accesses into pointer and data register
// updates, starts processor reads and writes, and latches read data.
// Assumes the serial slave gives one strobe per byte and honours stretch.
module ibr_bridge #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_sel,
    input  logic              host_lo,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_stretch,
    output logic              pr_req,
    output logic              pr_we,
    output logic [WORD_W-1:0] pr_addr,
    output logic [WORD_W-1:0] pr_wdata,
    input  logic              pr_ack,
    input  logic [WORD_W-1:0] pr_rdata
);
    import ibr_pkg::*;

    localparam int NREG = 3;

    ibr_sel_e          sel;
    logic              idle;
    logic [NREG-1:0]   reg_we;
    logic [NREG-1:0]   reg_ld;
    logic [WORD_W-1:0] reg_q [NREG];
    logic [WORD_W-1:0] reg_ldval [NREG];
    logic              start_rd;
    logic              start_wr;
    logic              wptr_valid;
    logic [BYTE_W-1:0] rd_byte;

    assign sel  = ibr_sel_e'(host_sel);
    assign idle = !pr_req;

    // Byte write enables per register; every write is blocked while busy.
    always_comb begin
        reg_we = '0;
        if (host_wr && idle && sel != SEL_NONE) reg_we[host_sel] = 1'b1;
    end

    // Only the data register takes a full-word load, from a read acknowledge.
    always_comb begin
        reg_ld       = '0;
        reg_ld[SEL_DATA] = pr_req && pr_ack && !pr_we;
        reg_ldval[SEL_RPTR] = '0;
        reg_ldval[SEL_WPTR] = '0;
        reg_ldval[SEL_DATA] = pr_rdata;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        ibr_word_reg #(.BYTE_W(BYTE_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .byte_we (reg_we[i]),
            .byte_lo (host_lo),
            .byte_in (host_wdata),
            .word_ld (reg_ld[i]),
            .word_in (reg_ldval[i]),
            .q       (reg_q[i])
        );
    end

    assign start_rd = reg_we[SEL_RPTR] && host_lo;
    assign start_wr = reg_we[SEL_DATA] && host_lo && wptr_valid;

    // Track whether a write pointer was completed since the last processor write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wptr_valid <= 1'b0;
        else if (start_wr)                         wptr_valid <= 1'b0;
        else if (reg_we[SEL_WPTR] && host_lo)      wptr_valid <= 1'b1;
    end

    ibr_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .rd_addr  ({reg_q[SEL_RPTR][WORD_W-1:BYTE_W], host_wdata}),
        .wr_addr  (reg_q[SEL_WPTR]),
        .ack      (pr_ack),
        .req      (pr_req),
        .we       (pr_we),
        .addr     (pr_addr)
    );

    assign pr_wdata = reg_q[SEL_DATA];

    // Readback multiplexer: pick the register, then the byte half.
    always_comb begin
        rd_byte = '0;
        if (sel != SEL_NONE) begin
            rd_byte = host_lo ? reg_q[host_sel][BYTE_W-1:0]
                              : reg_q[host_sel][WORD_W-1:BYTE_W];
        end
    end

    assign host_rdata   = rd_byte;
    assign host_stretch = pr_req && (host_wr || host_rd) && sel == SEL_DATA;
endmodule

// File: rtl/ibr_bridge_chk.sv
`timescale 1ns/1ps
// Protocol checker for ibr_bridge, attached with bind below.
// It observes ports only.
module ibr_bridge_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_sel_lo_dummy,
    input logic [1:0]        host_sel,
    input logic              host_lo,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              host_stretch,
    input logic              pr_req,
    input logic              pr_we,
    input logic [WORD_W-1:0] pr_addr,
    input logic [WORD_W-1:0] pr_wdata,
    input logic              pr_ack
);
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && !pr_ack |=> pr_req);

    p_drop_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && pr_ack |=> !pr_req);

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && !pr_ack |=> $stable(pr_addr) && $stable(pr_we));

    p_wdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req && !pr_ack |=> $stable(pr_wdata));

    p_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_stretch |-> pr_req && host_sel == 2'd2);

    p_rd_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_req) && !pr_we |-> $past(host_wr && host_sel == 2'd0 && host_lo));

    p_wr_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_req) && pr_we |-> $past(host_wr && host_sel == 2'd2 && host_lo));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel == 2'd3 |-> host_rdata == '0);

    p_idle_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !pr_req);
endmodule

bind ibr_bridge ibr_bridge_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .host_wr           (host_wr),
    .host_sel_lo_dummy (host_rd),
    .host_sel          (host_sel),
    .host_lo           (host_lo),
    .host_rdata        (host_rdata),
    .host_stretch      (host_stretch),
    .pr_req            (pr_req),
    .pr_we             (pr_we),
    .pr_addr           (pr_addr),
    .pr_wdata          (pr_wdata),
    .pr_ack            (pr_ack)
);

// File: tb/sim_ibr_bridge.sv
`timescale 1ns/1ps
// Bench for ibr_bridge: a host model with a register model, and a processor
// responder with a random acknowledge delay. Directed cases come first, then seeded random traffic.
module sim_ibr_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic          host_lo = 1'b0;
    logic [BW-1:0] host_wdata = '0;
    logic [BW-1:0] host_rdata;
    logic          host_stretch;
    logic          pr_req;
    logic          pr_we;
    logic [WW-1:0] pr_addr;
    logic [WW-1:0] pr_wdata;
    logic          pr_ack = 1'b0;
    logic [WW-1:0] pr_rdata = '0;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [WW-1:0] m_rptr = '0, m_wptr = '0, m_data = '0;
    bit            m_wvalid = 1'b0;
    bit            model_busy = 1'b0;
    bit            issue = 1'b0;
    bit            hold_ack = 1'b0;
    logic [WW-1:0] pend_addr = '0, pend_wd = '0;
    bit            pend_we = 1'b0;
    int unsigned   dly = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibr_bridge #(.BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_lo(host_lo), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_stretch(host_stretch),
        .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
        .pr_ack(pr_ack), .pr_rdata(pr_rdata)
    );

    // Processor memory contents as a function of address.
    function automatic logic [WW-1:0] mem_val(input logic [WW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // Expected byte for a host read.
    function automatic logic [BW-1:0] exp_byte(input logic [1:0] s, input bit lo);
        logic [WW-1:0] w;
        case (s)
            2'd0:    w = m_rptr;
            2'd1:    w = m_wptr;
            2'd2:    w = m_data;
            default: w = '0;
        endcase
        return lo ? w[7:0] : w[15:8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host byte access: drive, check combinational outputs, update model.
    task automatic host_op(input bit w, input logic [1:0] s, input bit lo, input logic [BW-1:0] b);
        bit exp_st;
        @(posedge clk); #1;
        host_wr = w; host_rd = !w; host_sel = s; host_lo = lo; host_wdata = b;
        exp_st = model_busy && s == 2'd2;
        #1;
        chk(host_stretch === exp_st, "R7 stretch", host_stretch, exp_st);
        if (!w) chk(host_rdata === exp_byte(s, lo), "R2/R4/R10 readback", host_rdata, exp_byte(s, lo));
        if (w && !model_busy) begin
            case (s)
                2'd0: begin
                    if (lo) m_rptr[7:0] = b; else m_rptr[15:8] = b;
                    if (lo) begin pend_addr = m_rptr; pend_we = 1'b0; issue = 1'b1; end
                end
                2'd1: begin
                    if (lo) m_wptr[7:0] = b; else m_wptr[15:8] = b;
                    if (lo) m_wvalid = 1'b1;
                end
                2'd2: begin
                    if (lo) m_data[7:0] = b; else m_data[15:8] = b;
                    if (lo && m_wvalid) begin
                        pend_addr = m_wptr; pend_wd = m_data; pend_we = 1'b1;
                        issue = 1'b1; m_wvalid = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (model_busy || issue) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // Processor responder; also checks that pr_req follows the model (R6, R3, R5).
    initial begin
        forever begin
            @(posedge clk);
            if (pr_ack) begin
                model_busy = 1'b0;
                if (!pend_we) m_data = mem_val(pend_addr);
            end
            if (issue) begin model_busy = 1'b1; issue = 1'b0; end
            #2;
            if (rst_n) begin
                chk(pr_req === model_busy, "R6/R3/R5 request level", pr_req, model_busy);
                if (pr_ack) pr_ack = 1'b0;
                else if (pr_req && model_busy && !hold_ack) begin
                    if (dly == 0) begin
                        chk(pr_addr === pend_addr, "R3/R5/R8 address", pr_addr, pend_addr);
                        chk(pr_we === pend_we, "R3/R5 direction", pr_we, pend_we);
                        if (pend_we) chk(pr_wdata === pend_wd, "R5/R9 write data", pr_wdata, pend_wd);
                        pr_rdata = mem_val(pend_addr);
                        pr_ack = 1'b1;
                        dly = $urandom % 4;
                    end else dly--;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(pr_req === 1'b0, "R1 req after reset", pr_req, 0);
        chk(host_stretch === 1'b0, "R1 stretch after reset", host_stretch, 0);
        for (int s = 0; s < 3; s++) begin
            host_op(1'b0, s[1:0], 1'b0, 8'h00);
            host_op(1'b0, s[1:0], 1'b1, 8'h00);
        end
        // R2 and R3: read pointer load, then R4 data readback
        host_op(1'b1, 2'd0, 1'b0, 8'h12);
        host_op(1'b1, 2'd0, 1'b1, 8'h34);
        wait_idle();
        host_op(1'b0, 2'd0, 1'b0, 8'h00);
        host_op(1'b0, 2'd2, 1'b0, 8'h00);
        host_op(1'b0, 2'd2, 1'b1, 8'h00);
        // R5: data write without a pointer load starts nothing
        host_op(1'b1, 2'd2, 1'b0, 8'hAB);
        host_op(1'b1, 2'd2, 1'b1, 8'hCD);
        @(posedge clk); #2;
        chk(pr_req === 1'b0, "R5 no request without pointer", pr_req, 0);
        // R8, R9: loads while a write is held pending
        hold_ack = 1'b1;
        host_op(1'b1, 2'd1, 1'b0, 8'hBE);
        host_op(1'b1, 2'd1, 1'b1, 8'hEF);
        host_op(1'b1, 2'd2, 1'b0, 8'h55);
        host_op(1'b1, 2'd2, 1'b1, 8'h66);
        host_op(1'b1, 2'd1, 1'b0, 8'h11);
        host_op(1'b1, 2'd1, 1'b1, 8'h22);
        host_op(1'b1, 2'd0, 1'b1, 8'h77);
        host_op(1'b1, 2'd2, 1'b0, 8'h99);
        host_op(1'b0, 2'd2, 1'b0, 8'h00);
        host_op(1'b0, 2'd1, 1'b0, 8'h00);
        host_op(1'b0, 2'd0, 1'b1, 8'h00);
        chk(pr_addr === 16'hBEEF, "R8 pending address held", pr_addr, 16'hBEEF);
        chk(pr_wdata === 16'h5566, "R9 pending data held", pr_wdata, 16'h5566);
        hold_ack = 1'b0;
        wait_idle();
        // R10: unused subaddress
        host_op(1'b1, 2'd3, 1'b0, 8'hFF);
        host_op(1'b1, 2'd3, 1'b1, 8'hFF);
        host_op(1'b0, 2'd3, 1'b0, 8'h00);
        host_op(1'b0, 2'd3, 1'b1, 8'h00);
        for (int s = 0; s < 3; s++) host_op(1'b0, s[1:0], 1'b1, 8'h00);
        // Random traffic
        for (int i = 0; i < 1500; i++) begin
            host_op(($urandom % 3) != 0, 2'($urandom % 4), 1'($urandom % 2), 8'($urandom));
        end
        wait_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule